// File: doc/BRIEF.md
# Controller Memory Buffer Property Register File

This block is the register slice of a storage controller that describes an on-controller memory buffer to the host. The host reads and writes 32-bit words through a small request/response port. The slice reports a capability bit, the buffer's placement in the PCI BAR space, its size and the kinds of traffic it may carry. It also holds one 64-bit control register, through which the host states its intent to use the buffer, enables the controller memory space and programs a controller base address. A status word reports whether that base address is acceptable.

Placement and size words stay hidden (they read as zero) until the host sets the intent bit. The control register is kept through a controller reset and a function-level reset. Only the power-on reset clears it. Those two soft resets do clear the port state, so any pending response is dropped. The decoded base address, byte size, a bad-base flag and a combined enable go out as plain signals to the address-checking logic next to this block.

The request side is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low during a soft reset. It is also low while a response is still pending and `rsp_ready` is low. A response is presented one cycle after its request is taken. It stays stable until it is consumed by `rsp_ready`. The byte size parameter (count times unit) must be a power of two.

Top module: `cmb_regfile`

## Requirements
- R1: After power-on reset the control words (50h, 54h) read zero, `buf_en` is 0 and `rsp_valid` is 0.
- R2: Word 04h (upper half of the 64-bit capability register at 00h) carries the buffer-supported flag in bit 25, which is bit 57 of the whole register. Every other bit of 00h and 04h reads zero.
- R3: The location word (38h) and the size word (3Ch) read zero while the intent bit is 0. Once the intent bit is 1 they read their contents. In the location word the BAR indicator is bits 2:0 and the offset is bits 31:12. In the size word the usage flags are bits 4:0 (bit 0 write data, bit 1 read data, bit 2 pointer lists, bit 3 completion queues, bit 4 submission queues), the unit is bits 10:8 and the count is bits 31:12.
- R4: The control register spans 50h (low) and 54h (high). Bit 0 is the intent bit and bit 1 is the memory-space enable. The base address bits 63:12 sit in bits 31:12 of 50h and in all of 54h. Bits 11:2 of 50h read zero whatever was written to them.
- R5: The control register and the decoded outputs derived from it keep their values through a controller reset (`ctrl_rst`) and a function-level reset (`flr`). A power-on reset (`por_n` low) clears them.
- R6: While `ctrl_rst` or `flr` is high, `req_ready` is low and no request is taken. A pending response is dropped at the next edge.
- R7: `buf_base` equals the programmed base with bits 11:0 zero. `buf_size` equals the count times the unit, where the unit codes 0 to 6 mean 4 KiB, 64 KiB, 1 MiB, 16 MiB, 256 MiB, 4 GiB and 64 GiB.
- R8: `buf_base_bad` and bit 0 of the status word (58h) are 1 when the base is not a multiple of the size, or when base plus size exceeds 2^64. A base that ends exactly at the top of the 64-bit space is valid.
- R9: `buf_en` is 1 exactly when the intent bit and the memory-space enable are both 1 and the base is not bad.
- R10: Writes to 00h, 04h, 38h, 3Ch, 58h, 5Ch and 60h change nothing. 5Ch and 60h return the elasticity-buffer size and sustained-write throughput parameters.
- R11: A response appears one cycle after its request is taken and holds `rsp_rdata` stable while `rsp_ready` is low. `req_ready` is low whenever a response is pending and `rsp_ready` is low. A write response carries zero data. A read returns the register contents as they were before any write taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ctrl_rst | input | 1 | Controller reset, synchronous, active high |
| flr | input | 1 | Function-level reset, synchronous, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Byte offset; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Read data, zero for writes |
| buf_base | output | 64 | Decoded controller base address |
| buf_size | output | 64 | Buffer size in bytes |
| buf_en | output | 1 | Buffer address range active |
| buf_base_bad | output | 1 | Programmed base is misaligned or overflows |

## Verification
A write that is taken on edge N changes `buf_base`, `buf_base_bad` and `buf_en` right after edge N, because these are combinational from the control register. The response to the request taken on edge N is valid right after edge N and stays until an edge where `rsp_ready` is high. A soft reset clears it at the edge where the reset is sampled. A behavioural model in the bench advances on every rising edge from the same sampled inputs. All outputs are compared a quarter period after each edge, while the inputs are changed only on falling edges. Read data is therefore compared in the cycle in which the response is presented, and `req_ready` is compared against the inputs that the same edge will sample.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam logic [7:0] OFF_CAP_LO = 8'h00;
  localparam logic [7:0] OFF_CAP_HI = 8'h04;
  localparam logic [7:0] OFF_LOC    = 8'h38;
  localparam logic [7:0] OFF_SIZE   = 8'h3C;
  localparam logic [7:0] OFF_CTL_LO = 8'h50;
  localparam logic [7:0] OFF_CTL_HI = 8'h54;
  localparam logic [7:0] OFF_STAT   = 8'h58;
  localparam logic [7:0] OFF_EBUF   = 8'h5C;
  localparam logic [7:0] OFF_WTHR   = 8'h60;

  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned BASE_W    = 64 - PAGE_BITS;
  localparam int unsigned MAX_UNIT  = 6;

  typedef struct packed {
    logic [BASE_W-1:0] base_pg;
    logic              mem_en;
    logic              intent;
  } ctl_t;
endpackage

// File: rtl/cmb_ctl_reg.sv
module cmb_ctl_reg
  import cmb_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output ctl_t        ctl
);
  // Only the power-on reset touches this register; the soft resets never reach it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl <= '0;
    end else begin
      if (wr_lo) begin
        ctl.intent                 <= wdata[0];
        ctl.mem_en                 <= wdata[1];
        ctl.base_pg[19:0]          <= wdata[31:12];
      end
      if (wr_hi) begin
        ctl.base_pg[BASE_W-1:20]   <= wdata;
      end
    end
  end
endmodule

// File: rtl/cmb_base_check.sv
module cmb_base_check
  import cmb_pkg::*;
#(
  parameter logic [19:0] SIZE_CNT  = 20'd16,
  parameter logic [2:0]  SIZE_UNIT = 3'd1
) (
  input  ctl_t        ctl,
  output logic [63:0] base,
  output logic [63:0] size,
  output logic        bad,
  output logic        enable
);
  localparam int unsigned SHIFT = PAGE_BITS + 4 * int'(SIZE_UNIT);
  localparam logic [63:0] SIZE_B =
    (int'(SIZE_UNIT) > MAX_UNIT) ? 64'd0 : (64'(SIZE_CNT) << SHIFT);
  localparam logic [64:0] TOP = {1'b1, 64'd0};

  logic [64:0] end_sum;
  logic        misalign;
  logic        overflow;

  always_comb begin
    base     = {ctl.base_pg, {PAGE_BITS{1'b0}}};
    size     = SIZE_B;
    end_sum  = {1'b0, base} + {1'b0, SIZE_B};
    misalign = |(base & (SIZE_B - 64'd1));
    overflow = end_sum > TOP;
    bad      = (SIZE_B == 64'd0) || misalign || overflow;
    enable   = ctl.intent && ctl.mem_en && !bad;
  end
endmodule

// File: rtl/cmb_req_port.sv
module cmb_req_port (
  input  logic        clk,
  input  logic        por_n,
  input  logic        soft_rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] rd_word,
  input  logic        rsp_ready,
  output logic        req_ready,
  output logic        accept,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  always_comb begin
    req_ready = !soft_rst && (!rsp_valid || rsp_ready);
    accept    = req_valid && req_ready;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (soft_rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? 32'd0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmb_regfile.sv
module cmb_regfile
  import cmb_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter bit          CAP_HAS   = 1'b1,
  parameter logic [2:0]  LOC_BAR   = 3'd2,
  parameter logic [19:0] LOC_OFS   = 20'h00010,
  parameter logic [19:0] SIZE_CNT  = 20'd16,
  parameter logic [2:0]  SIZE_UNIT = 3'd1,
  parameter logic [4:0]  USE_FLAGS = 5'b10111,
  parameter logic [31:0] EBUF_VAL  = 32'h0000_0105,
  parameter logic [31:0] WTHR_VAL  = 32'h0000_0203
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ctrl_rst,
  input  logic          flr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic [63:0]   buf_base,
  output logic [63:0]   buf_size,
  output logic          buf_en,
  output logic          buf_base_bad
);
  logic          soft_rst;
  logic          accept;
  logic [AW-1:0] waddr;
  logic [31:0]   rd_word;
  logic          wr_lo;
  logic          wr_hi;
  ctl_t          ctl;

  assign soft_rst = ctrl_rst | flr;
  assign waddr    = {req_addr[AW-1:2], 2'b00};
  assign wr_lo    = accept && req_write && (waddr == AW'(OFF_CTL_LO));
  assign wr_hi    = accept && req_write && (waddr == AW'(OFF_CTL_HI));

  cmb_req_port u_port (
    .clk       (clk),
    .por_n     (por_n),
    .soft_rst  (soft_rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rd_word   (rd_word),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .accept    (accept),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  cmb_ctl_reg u_ctl (
    .clk   (clk),
    .por_n (por_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (req_wdata),
    .ctl   (ctl)
  );

  cmb_base_check #(
    .SIZE_CNT  (SIZE_CNT),
    .SIZE_UNIT (SIZE_UNIT)
  ) u_chk_base (
    .ctl    (ctl),
    .base   (buf_base),
    .size   (buf_size),
    .bad    (buf_base_bad),
    .enable (buf_en)
  );

  // Read word selection; the placement and size words stay hidden until intent is set.
  always_comb begin
    rd_word = '0;
    case (waddr)
      AW'(OFF_CAP_HI): rd_word = {6'd0, CAP_HAS, 25'd0};
      AW'(OFF_LOC):    rd_word = ctl.intent ? {LOC_OFS, 9'd0, LOC_BAR} : 32'd0;
      AW'(OFF_SIZE):   rd_word = ctl.intent ?
                         {SIZE_CNT, 1'b0, SIZE_UNIT, 3'd0, USE_FLAGS} : 32'd0;
      AW'(OFF_CTL_LO): rd_word = {ctl.base_pg[19:0], 10'd0, ctl.mem_en, ctl.intent};
      AW'(OFF_CTL_HI): rd_word = ctl.base_pg[BASE_W-1:20];
      AW'(OFF_STAT):   rd_word = {31'd0, buf_base_bad};
      AW'(OFF_EBUF):   rd_word = EBUF_VAL;
      AW'(OFF_WTHR):   rd_word = WTHR_VAL;
      default:         rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cmb_regfile_chk.sv
module cmb_regfile_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          por_n,
  input logic          ctrl_rst,
  input logic          flr,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic [63:0]   buf_base,
  input logic [63:0]   buf_size,
  input logic          buf_en,
  input logic          buf_base_bad
);
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!por_n)
    rsp_valid && !rsp_ready && !ctrl_rst && !flr |=> rsp_valid && $stable(rsp_rdata));

  a_r11_ready_block: assert property (@(posedge clk) disable iff (!por_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r6_soft_drop: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_rst || flr) |=> !rsp_valid);

  a_r6_soft_stall: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_rst || flr) |-> !req_ready);

  a_r5_keep_ctl: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_rst || flr) |=> $stable(buf_base) && $stable(buf_en));

  a_r9_en_needs_good: assert property (@(posedge clk) disable iff (!por_n)
    buf_en |-> !buf_base_bad);

  a_r8_good_is_aligned: assert property (@(posedge clk) disable iff (!por_n)
    !buf_base_bad |-> ((buf_base & (buf_size - 64'd1)) == 64'd0));
endmodule

bind cmb_regfile cmb_regfile_chk #(.AW(AW)) u_regfile_chk (
  .clk          (clk),
  .por_n        (por_n),
  .ctrl_rst     (ctrl_rst),
  .flr          (flr),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .buf_base     (buf_base),
  .buf_size     (buf_size),
  .buf_en       (buf_en),
  .buf_base_bad (buf_base_bad)
);

// File: tb/test_cmb_regfile.sv
module test_cmb_regfile;
  localparam int CLK_PER = 10;
  localparam logic [2:0]  P_BAR  = 3'd2;
  localparam logic [19:0] P_OFS  = 20'h00010;
  localparam logic [19:0] P_CNT  = 20'd16;
  localparam logic [2:0]  P_UNIT = 3'd1;
  localparam logic [4:0]  P_USE  = 5'b10111;
  localparam logic [31:0] P_EBUF = 32'h0000_0105;
  localparam logic [31:0] P_WTHR = 32'h0000_0203;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        ctrl_rst = 1'b0;
  logic        flr = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [63:0] buf_base;
  logic [63:0] buf_size;
  logic        buf_en;
  logic        buf_base_bad;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  always #(CLK_PER/2) clk = ~clk;

  cmb_regfile #(
    .AW(8), .CAP_HAS(1'b1), .LOC_BAR(P_BAR), .LOC_OFS(P_OFS),
    .SIZE_CNT(P_CNT), .SIZE_UNIT(P_UNIT), .USE_FLAGS(P_USE),
    .EBUF_VAL(P_EBUF), .WTHR_VAL(P_WTHR)
  ) i_cmb_regfile (
    .clk(clk), .por_n(por_n), .ctrl_rst(ctrl_rst), .flr(flr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .buf_base(buf_base),
    .buf_size(buf_size), .buf_en(buf_en), .buf_base_bad(buf_base_bad)
  );

  // ---------------- behavioural reference ----------------
  bit          m_intent = 0;
  bit          m_memen = 0;
  logic [63:0] m_base = '0;
  bit          m_rv = 0;
  logic [31:0] m_rd = '0;

  function automatic logic [63:0] unit_bytes(input logic [2:0] u);
    case (u)
      3'd0: return 64'd4096;
      3'd1: return 64'd65536;
      3'd2: return 64'd1048576;
      3'd3: return 64'd16777216;
      3'd4: return 64'd268435456;
      3'd5: return 64'd4294967296;
      3'd6: return 64'd68719476736;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [63:0] exp_size();
    return 64'(P_CNT) * unit_bytes(P_UNIT);
  endfunction

  function automatic bit exp_bad();
    logic [64:0] sum;
    logic [63:0] sz;
    sz = exp_size();
    if (sz == 0) return 1;
    sum = {1'b0, m_base} + {1'b0, sz};
    return ((m_base % sz) != 0) || (sum > {1'b1, 64'd0});
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] w;
    w = 0;
    case (a & 8'hFC)
      8'h04: w = 32'h0200_0000;
      8'h38: if (m_intent) w = (32'(P_OFS) << 12) | 32'(P_BAR);
      8'h3C: if (m_intent) w = (32'(P_CNT) << 12) | (32'(P_UNIT) << 8) | 32'(P_USE);
      8'h50: w = m_base[31:0] | {30'd0, m_memen, m_intent};
      8'h54: w = m_base[63:32];
      8'h58: w = {31'd0, exp_bad()};
      8'h5C: w = P_EBUF;
      8'h60: w = P_WTHR;
      default: w = 0;
    endcase
    return w;
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_intent = 0; m_memen = 0; m_base = '0; m_rv = 0; m_rd = '0;
    end else if (ctrl_rst || flr) begin
      m_rv = 0;
    end else if (req_valid && (!m_rv || rsp_ready)) begin
      m_rd = req_write ? 32'd0 : m_read(req_addr);
      m_rv = 1;
      if (req_write && (req_addr & 8'hFC) == 8'h50) begin
        m_intent = req_wdata[0];
        m_memen  = req_wdata[1];
        m_base[31:0] = {req_wdata[31:12], 12'd0};
      end
      if (req_write && (req_addr & 8'hFC) == 8'h54) m_base[63:32] = req_wdata;
    end else if (rsp_ready) begin
      m_rv = 0;
    end
  end

  task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (!done) begin
      cmp("req_ready", 64'(req_ready), 64'(!(ctrl_rst || flr) && (!m_rv || rsp_ready)));
      cmp("rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) cmp("rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
      cmp("buf_base", buf_base, m_base);
      cmp("buf_size", buf_size, exp_size());
      cmp("buf_base_bad", 64'(buf_base_bad), 64'(exp_bad()));
      cmp("buf_en", 64'(buf_en), 64'(m_intent && m_memen && !exp_bad()));
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input bit w, input logic [7:0] a, input logic [31:0] d);
    logic r;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (1) begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
    req_valid = 0;
  endtask

  task automatic final_report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      final_report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    tag = "R1";
    xfer(0, 8'h50, 0); xfer(0, 8'h54, 0);
    tag = "R2";
    xfer(0, 8'h00, 0); xfer(0, 8'h04, 0);
    tag = "R3";
    xfer(0, 8'h38, 0); xfer(0, 8'h3C, 0);
    tag = "R4";
    xfer(1, 8'h50, 32'h0000_0FFD);
    xfer(0, 8'h50, 0);
    tag = "R3";
    xfer(0, 8'h38, 0); xfer(0, 8'h3C, 0);
    tag = "R7";
    xfer(1, 8'h50, 32'h0010_0003);
    xfer(1, 8'h54, 32'h0000_00A5);
    xfer(0, 8'h54, 0);
    tag = "R8";
    xfer(1, 8'h50, 32'h0010_1003);
    xfer(0, 8'h58, 0);
    xfer(1, 8'h54, 32'hFFFF_FFFF);
    xfer(1, 8'h50, 32'hFFF0_0003);
    xfer(0, 8'h58, 0);
    tag = "R9";
    xfer(1, 8'h50, 32'hFFF0_0001);
    xfer(1, 8'h50, 32'h0020_0002);
    xfer(1, 8'h50, 32'h0020_0003);
    tag = "R10";
    xfer(1, 8'h00, 32'hFFFF_FFFF); xfer(1, 8'h04, 32'h0);
    xfer(1, 8'h38, 32'h0); xfer(1, 8'h3C, 32'h0);
    xfer(1, 8'h58, 32'hFFFF_FFFF); xfer(1, 8'h5C, 32'h0);
    xfer(1, 8'h60, 32'h0);
    xfer(0, 8'h04, 0); xfer(0, 8'h38, 0); xfer(0, 8'h3C, 0);
    xfer(0, 8'h58, 0); xfer(0, 8'h5C, 0); xfer(0, 8'h60, 0);
    xfer(0, 8'h50, 0);
    tag = "R11";
    @(negedge clk); rsp_ready = 0;
    xfer(0, 8'h5C, 0);
    fork
      xfer(0, 8'h60, 0);
      begin repeat (4) @(negedge clk); rsp_ready = 1; end
    join
    tag = "R6";
    @(negedge clk); rsp_ready = 0;
    xfer(0, 8'h54, 0);
    @(negedge clk);
    ctrl_rst = 1; req_valid = 1; req_write = 1; req_addr = 8'h50; req_wdata = 32'h0;
    @(negedge clk);
    ctrl_rst = 0; req_valid = 0; rsp_ready = 1;
    tag = "R5";
    xfer(0, 8'h50, 0);
    @(negedge clk); flr = 1;
    @(negedge clk); flr = 0;
    xfer(0, 8'h50, 0); xfer(0, 8'h54, 0);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    xfer(0, 8'h50, 0); xfer(0, 8'h3C, 0);
    repeat (2) @(negedge clk);
    done = 1;
    final_report();
  end
endmodule